// File: doc/BRIEF.md
# Descriptor-Chained Receive DMA Engine

This block is the receive half of one DMA channel. A client pushes a byte stream, one byte per beat, with a flag marking the last byte of a packet. The engine writes each byte into memory at the current position of the active data descriptor. It closes that descriptor either when its buffer is full or when a packet ends. After closing, it continues with the next descriptor in the chain.

A descriptor is four 32-bit words at consecutive word addresses: link to the next descriptor (offset 0), buffer start (offset 4), flags (offset 8) and buffer end, exclusive (offset 12). Software starts the channel by giving the first descriptor address and a context address. When a descriptor closes, the engine rewrites its flags word and its end word, so software can see how much was actually filled. It raises interrupt bits as the flags ask. When the closed descriptor carries the end-of-list flag, the engine marks the context disabled and stops.

Top module: `rxdma_engine`

## Requirements
- R1: After reset the channel is stopped: `chan_stopped`=1, `s_ready`=0, `mem_req`=0, `intr_raw`=0 and `irq`=0.
- R2: On start, and again when chaining, the engine reads the four descriptor words in the order offset 0, 4, 8, 12, relative to the descriptor address.
- R3: Bytes are packed little-endian. A byte for address p goes to lane p[1:0] of the 32-bit word at p with bits 1:0 cleared, and sets the byte-enable bit for that lane. A word is written when lane 3 has been filled, or earlier when the descriptor closes.
- R4: A descriptor accepts bytes only up to its end address. When the position reaches the end address the descriptor closes, and the next byte goes to the start of the next descriptor's buffer.
- R5: A byte with `s_last`=1 closes the descriptor at once. The end word (offset 12) is then rewritten to the address just past that byte, and flags bit 11 is set.
- R6: Closing writes the flags word (offset 8) first and the end word (offset 12) second, each with all byte enables set. The flags word keeps the bits that were loaded.
- R7: A close raises `intr_raw` bits 0 and 1 if flags bit 4 is set, and raises `intr_raw` bit 3 if the descriptor closed on `s_last`.
- R8: `irq` is the OR of `intr_raw & intr_mask`. A one-cycle pulse on an `intr_ack` bit clears that raw bit, unless the same cycle sets it.
- R9: After the write-back of a descriptor whose flags bit 0 (end of list) is set, the engine writes the context word at the context address with byte enable 4'b0010 and data bit 15 set. It then stops. While stopped, `s_ready` stays 0 and offered bytes cause no memory writes and no change to `intr_raw`.
- R10: `s_ready` is low whenever a memory request is pending (descriptor fetch, data write or write-back).
- R11: A descriptor whose buffer start equals its end closes right after the fetch. No byte is accepted and no data word is written; the flags and end words are still written back.
- R12: A start while stopped restarts the channel at the new descriptor address with a new context address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, taken only while stopped |
| start_desc | input | DW | First descriptor address |
| start_ctx | input | DW | Context word address |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Last byte of a packet |
| s_ready | output | 1 | Engine takes the byte on this edge |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | DW | Byte address, word aligned |
| mem_wdata | output | DW | Write data |
| mem_be | output | DW/8 | Write byte enables |
| mem_ack | input | 1 | One-cycle acknowledge of the pending request |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |
| intr_mask | input | IRQW | Interrupt enable mask |
| intr_ack | input | IRQW | Interrupt clear pulses |
| intr_raw | output | IRQW | Raw interrupt bits |
| irq | output | 1 | Masked interrupt request |
| chan_stopped | output | 1 | Channel idle (end of list reached or never started) |

## Verification
The assertions assume the memory side answers only a pending request, with exactly one acknowledge pulse per request. They also assume every descriptor's end address is at or above its buffer start, and that `start` is pulsed only while the channel is stopped. The bench memory model acknowledges one cycle after it sees a request and drops the acknowledge on the following cycle. All descriptors in the bench are set up with end ≥ start, and the bench starts the channel only after reset or after it has seen `chan_stopped`. The bench holds stream bytes stable until they are taken.

// File: rtl/rxdma_pkg.sv
// Shared types and field positions for the receive DMA engine.
// Assumes 32-bit descriptor words; the bit positions are fixed by the
// descriptor format that software and the engine share.
package rxdma_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH,
        ST_STREAM,
        ST_FLUSH,
        ST_CLOSE,
        ST_WB_FLAGS,
        ST_WB_AFTER,
        ST_CTX_DIS
    } rx_state_e;

    // Flags word bits
    localparam int FLG_EOL    = 0;
    localparam int FLG_INTR   = 4;
    localparam int FLG_IN_EOP = 11;

    // Context word bit marking the context disabled
    localparam int CTX_DIS_BIT = 15;

    // Raw interrupt bit positions
    localparam int IRQ_DATA_A = 0;
    localparam int IRQ_DATA_B = 1;
    localparam int IRQ_IN_EOP = 3;

    // Descriptor word indices
    localparam int W_NEXT  = 0;
    localparam int W_BUF   = 1;
    localparam int W_FLAGS = 2;
    localparam int W_AFTER = 3;

endpackage

// File: rtl/rxdma_packer.sv
// Byte-to-word packer: collects stream bytes into the lanes of one memory
// word and tracks which lanes hold data.
// Assumes the controller never loads a lane twice before clearing, and
// never loads and clears in the same cycle.
module rxdma_packer #(
    parameter int LANES = 4,
    localparam int LB = $clog2(LANES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [LB-1:0]      lane,
    input  logic [7:0]         din,
    input  logic               clear,
    output logic [8*LANES-1:0] data,
    output logic [LANES-1:0]   be
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Capture the byte aimed at this lane and mark the lane filled
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data[8*g +: 8] <= '0;
                be[g]          <= 1'b0;
            end else if (clear) begin
                be[g] <= 1'b0;
            end else if (load && (lane == LB'(g))) begin
                data[8*g +: 8] <= din;
                be[g]          <= 1'b1;
            end
        end
    end

    // R3: a lane is never overwritten before the word is written out
    a_r3_no_lane_reuse: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !be[lane]);

endmodule

// File: rtl/rxdma_irq.sv
// Raw interrupt register with clear pulses and a masked request output.
// Assumes set and ack are single-cycle pulses; set wins over ack.
module rxdma_irq #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] ack,
    input  logic [W-1:0] mask,
    output logic [W-1:0] raw,
    output logic         irq
);

    // Hold raw bits: clear on ack, set on events
    always_ff @(posedge clk) begin
        if (!rst_n) raw <= '0;
        else        raw <= (raw & ~ack) | set;
    end

    // Request is any enabled raw bit
    always_comb irq = |(raw & mask);

    // R8: an acknowledged bit not set again in that cycle is clear afterwards
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ack & ~set)) |=> ((raw & $past(ack & ~set)) == '0));

    // R7: a set bit is visible on the next cycle
    a_r7_set_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (|set) |=> ((raw & $past(set)) == $past(set)));

endmodule

// File: rtl/rxdma_engine.sv
// Receive DMA engine for one channel: fetches data descriptors, packs
// stream bytes into memory words, closes descriptors on full buffer or
// end of packet, writes them back, raises interrupts and follows the chain.
// Assumes one acknowledge per memory request and descriptors with end >= start.
module rxdma_engine
    import rxdma_pkg::*;
#(
    parameter int DW   = 32,
    parameter int IRQW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [DW-1:0]   start_desc,
    input  logic [DW-1:0]   start_ctx,
    input  logic            s_valid,
    input  logic [7:0]      s_data,
    input  logic            s_last,
    output logic            s_ready,
    output logic            mem_req,
    output logic            mem_we,
    output logic [DW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic [DW/8-1:0] mem_be,
    input  logic            mem_ack,
    input  logic [DW-1:0]   mem_rdata,
    input  logic [IRQW-1:0] intr_mask,
    input  logic [IRQW-1:0] intr_ack,
    output logic [IRQW-1:0] intr_raw,
    output logic            irq,
    output logic            chan_stopped
);

    localparam int LANES    = DW / 8;
    localparam int LB       = $clog2(LANES);
    localparam int CTX_LANE = CTX_DIS_BIT / 8;

    rx_state_e       state;
    logic [DW-1:0]   desc_q, ctx_q, next_q, flags_q, after_q, pos_q, wr_addr_q;
    logic [1:0]      fidx_q;
    logic            close_q, eop_q;

    logic [LB-1:0]   lane;
    logic            take;
    logic            done;
    logic            pk_clear;
    logic [DW-1:0]   pk_data;
    logic [LANES-1:0] pk_be;
    logic [IRQW-1:0] irq_set;
    logic            closing;

    always_comb begin
        lane     = pos_q[LB-1:0];
        s_ready  = (state == ST_STREAM);
        take     = s_ready && s_valid;
        done     = ((pos_q + DW'(1)) == after_q) || s_last;
        pk_clear = (state == ST_FLUSH) && mem_ack;
        closing  = (state == ST_CLOSE);
        chan_stopped = (state == ST_IDLE);
    end

    rxdma_packer #(.LANES(LANES)) u_pack (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (take),
        .lane  (lane),
        .din   (s_data),
        .clear (pk_clear),
        .data  (pk_data),
        .be    (pk_be)
    );

    // Interrupt events raised by a descriptor close
    always_comb begin
        irq_set             = '0;
        irq_set[IRQ_DATA_A] = closing && flags_q[FLG_INTR];
        irq_set[IRQ_DATA_B] = closing && flags_q[FLG_INTR];
        irq_set[IRQ_IN_EOP] = closing && eop_q;
    end

    rxdma_irq #(.W(IRQW)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (irq_set),
        .ack   (intr_ack),
        .mask  (intr_mask),
        .raw   (intr_raw),
        .irq   (irq)
    );

    // Memory request mux: one source per state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_be    = '0;
        unique case (state)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = desc_q + (DW'(fidx_q) << LB);
            end
            ST_FLUSH: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = wr_addr_q;
                mem_wdata = pk_data;
                mem_be    = pk_be;
            end
            ST_WB_FLAGS: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_q + (DW'(W_FLAGS) << LB);
                mem_wdata = flags_q;
                mem_be    = '1;
            end
            ST_WB_AFTER: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_q + (DW'(W_AFTER) << LB);
                mem_wdata = after_q;
                mem_be    = '1;
            end
            ST_CTX_DIS: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ctx_q;
                mem_wdata = DW'(1) << CTX_DIS_BIT;
                mem_be    = LANES'(1) << CTX_LANE;
            end
            default: ;
        endcase
    end

    // Channel sequencer: fetch, stream, flush, close, write back, chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            desc_q    <= '0;
            ctx_q     <= '0;
            next_q    <= '0;
            flags_q   <= '0;
            after_q   <= '0;
            pos_q     <= '0;
            wr_addr_q <= '0;
            fidx_q    <= '0;
            close_q   <= 1'b0;
            eop_q     <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    desc_q <= start_desc;
                    ctx_q  <= start_ctx;
                    fidx_q <= '0;
                    eop_q  <= 1'b0;
                    state  <= ST_FETCH;
                end
                ST_FETCH: if (mem_ack) begin
                    case (fidx_q)
                        2'(W_NEXT):  next_q  <= mem_rdata;
                        2'(W_BUF):   pos_q   <= mem_rdata;
                        2'(W_FLAGS): flags_q <= mem_rdata;
                        default:     after_q <= mem_rdata;
                    endcase
                    fidx_q <= fidx_q + 2'd1;
                    if (fidx_q == 2'(W_AFTER))
                        state <= (pos_q == mem_rdata) ? ST_CLOSE : ST_STREAM;
                end
                ST_STREAM: if (s_valid) begin
                    pos_q     <= pos_q + DW'(1);
                    wr_addr_q <= {pos_q[DW-1:LB], {LB{1'b0}}};
                    eop_q     <= s_last;
                    close_q   <= done;
                    if (done || (lane == LB'(LANES - 1)))
                        state <= ST_FLUSH;
                end
                ST_FLUSH: if (mem_ack)
                    state <= close_q ? ST_CLOSE : ST_STREAM;
                ST_CLOSE: begin
                    flags_q[FLG_IN_EOP] <= flags_q[FLG_IN_EOP] | eop_q;
                    after_q <= pos_q;
                    state   <= ST_WB_FLAGS;
                end
                ST_WB_FLAGS: if (mem_ack) state <= ST_WB_AFTER;
                ST_WB_AFTER: if (mem_ack) begin
                    if (flags_q[FLG_EOL]) begin
                        state <= ST_CTX_DIS;
                    end else begin
                        desc_q <= next_q;
                        fidx_q <= '0;
                        eop_q  <= 1'b0;
                        state  <= ST_FETCH;
                    end
                end
                ST_CTX_DIS: if (mem_ack) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R10: the stream is never taken while memory is busy
    a_r10_ready_excl_mem: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> !mem_req);

    // R2: a request stays put until acknowledged
    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R4: while streaming, the position never sits at the end address
    a_r4_pos_within: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STREAM) |-> (pos_q != after_q));

    // R3: every data write carries at least one lane
    a_r3_flush_has_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLUSH) |-> (pk_be != '0));

    // R9: the context write ends the run
    a_r9_stop_after_ctx: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CTX_DIS && mem_ack) |=> (chan_stopped && !s_ready));

    // R7: a close with the descriptor interrupt bit raises bits 0 and 1
    a_r7_intr_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (closing && flags_q[FLG_INTR]) |=> (intr_raw[IRQ_DATA_A] && intr_raw[IRQ_DATA_B]));

endmodule

// File: tb/tb_rxdma_engine.sv
// Scoreboard bench: the driver runs a requirement-level model that pushes
// expected memory writes; a monitor pops and compares actual writes.
module tb_rxdma_engine;

    localparam int DW = 32;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [31:0] start_desc, start_ctx;
    logic        s_valid, s_last, s_ready;
    logic [7:0]  s_data;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be;
    logic [3:0]  intr_mask, intr_ack, intr_raw;
    logic        irq, chan_stopped;

    always #2 clk = ~clk;

    rxdma_engine #(.DW(DW), .IRQW(4)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_desc(start_desc),
        .start_ctx(start_ctx), .s_valid(s_valid), .s_data(s_data),
        .s_last(s_last), .s_ready(s_ready), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .intr_mask(intr_mask), .intr_ack(intr_ack), .intr_raw(intr_raw),
        .irq(irq), .chan_stopped(chan_stopped)
    );

    int checks = 0;
    int errors = 0;
    int overlap = 0;
    int rd_idx = 0;

    task automatic check(bit ok, string req, string what,
                         logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Memory model: word-indexed, acknowledges one cycle after a request
    logic [31:0] mem     [int unsigned];
    logic [31:0] ref_mem [int unsigned];

    function automatic logic [31:0] rd(logic [31:0] a);
        return ref_mem.exists(a >> 2) ? ref_mem[a >> 2] : 32'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                logic [31:0] w;
                w = mem.exists(mem_addr >> 2) ? mem[mem_addr >> 2] : 32'h0;
                for (int i = 0; i < 4; i++)
                    if (mem_be[i]) w[8*i +: 8] = mem_wdata[8*i +: 8];
                mem[mem_addr >> 2] = w;
            end else begin
                mem_rdata <= mem.exists(mem_addr >> 2) ? mem[mem_addr >> 2] : 32'h0;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // Expected writes
    typedef struct {
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  be;
        string       req;
    } wr_t;
    wr_t exp_q[$];

    task automatic push(logic [31:0] a, logic [31:0] d, logic [3:0] be, string req);
        wr_t w;
        w.addr = a; w.data = d; w.be = be; w.req = req;
        exp_q.push_back(w);
    endtask

    function automatic logic [31:0] bmask(logic [3:0] be);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
        return m;
    endfunction

    // Monitor: compare writes, check read order, watch ready/request overlap
    always @(negedge clk) begin
        if (rst_n && s_ready && mem_req) overlap++;
        if (rst_n && mem_req && mem_ack) begin
            if (mem_we) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected write addr", mem_addr, 32'h0);
                end else begin
                    wr_t e;
                    e = exp_q.pop_front();
                    check(mem_addr == e.addr, e.req, "write addr", mem_addr, e.addr);
                    check(mem_be == e.be, e.req, "write be", {28'h0, mem_be}, {28'h0, e.be});
                    check((mem_wdata & bmask(e.be)) == (e.data & bmask(e.be)), e.req,
                          "write data", mem_wdata & bmask(e.be), e.data & bmask(e.be));
                end
            end else begin
                // R2: descriptor words read at offsets 0,4,8,12 in turn
                check(mem_addr[3:0] == 4'(rd_idx * 4), "R2", "fetch offset",
                      {28'h0, mem_addr[3:0]}, 32'(rd_idx * 4));
                rd_idx = (rd_idx + 1) % 4;
            end
        end
    end

    // Reference model of the descriptor walk
    logic [31:0] m_desc, m_next, m_flags, m_after, m_pos, m_ctx, pk_data, pk_addr;
    logic [3:0]  pk_be, exp_raw;
    bit          m_stopped;

    task automatic m_close(bit eop);
        string tag;
        tag = eop ? "R5" : ((m_pos == rd(m_desc + 4)) ? "R11" : "R4");
        if (m_flags[4]) exp_raw |= 4'b0011;
        if (eop)        exp_raw |= 4'b1000;
        push(m_desc + 8,  m_flags | (32'(eop) << 11), 4'hF, "R6");
        push(m_desc + 12, m_pos, 4'hF, tag);
        if (m_flags[0]) begin
            push(m_ctx, 32'h0000_8000, 4'b0010, "R9");
            m_stopped = 1'b1;
        end else begin
            m_load(m_next);
        end
    endtask

    task automatic m_load(logic [31:0] d);
        m_desc  = d;
        m_next  = rd(d);
        m_pos   = rd(d + 4);
        m_flags = rd(d + 8);
        m_after = rd(d + 12);
        pk_be   = 4'h0;
        pk_data = 32'h0;
        if (m_pos == m_after) m_close(1'b0);
    endtask

    task automatic m_byte(logic [7:0] b, bit last);
        logic [1:0] ln;
        bit dn;
        ln = m_pos[1:0];
        pk_data[8*ln +: 8] = b;
        pk_be[ln] = 1'b1;
        pk_addr = {m_pos[31:2], 2'b00};
        m_pos = m_pos + 1;
        dn = (m_pos == m_after) || last;
        if (dn || ln == 2'd3) begin
            push(pk_addr, pk_data, pk_be, "R3");
            pk_be = 4'h0;
            pk_data = 32'h0;
        end
        if (dn) m_close(last);
    endtask

    // Driver tasks (called at a falling edge)
    task automatic send(logic [7:0] b, bit last);
        m_byte(b, last);
        s_valid = 1'b1; s_data = b; s_last = last;
        while (!s_ready) @(negedge clk);
        @(negedge clk);
        s_valid = 1'b0; s_last = 1'b0;
    endtask

    task automatic start_chan(logic [31:0] d, logic [31:0] ctx);
        m_ctx = ctx;
        m_stopped = 1'b0;
        rd_idx = 0;
        m_load(d);
        start = 1'b1; start_desc = d; start_ctx = ctx;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_stopped();
        int n = 0;
        @(negedge clk);
        while (!chan_stopped && n < 2000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic put_desc(logic [31:0] a, logic [31:0] nx, logic [31:0] bf,
                            logic [31:0] fl, logic [31:0] af);
        mem[a >> 2] = nx;       ref_mem[a >> 2] = nx;
        mem[(a >> 2) + 1] = bf; ref_mem[(a >> 2) + 1] = bf;
        mem[(a >> 2) + 2] = fl; ref_mem[(a >> 2) + 2] = fl;
        mem[(a >> 2) + 3] = af; ref_mem[(a >> 2) + 3] = af;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; start_desc = '0; start_ctx = '0;
        s_valid = 1'b0; s_data = '0; s_last = 1'b0;
        intr_mask = 4'b1000; intr_ack = 4'h0; exp_raw = 4'h0;
        mem_rdata = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(chan_stopped == 1'b1, "R1", "chan_stopped", {31'h0, chan_stopped}, 32'h1);
        check(s_ready == 1'b0, "R1", "s_ready", {31'h0, s_ready}, 32'h0);
        check(mem_req == 1'b0, "R1", "mem_req", {31'h0, mem_req}, 32'h0);
        check(intr_raw == 4'h0 && irq == 1'b0, "R1", "intr_raw/irq",
              {27'h0, irq, intr_raw}, 32'h0);

        // Chain: unaligned 6-byte buffer with intr, 16-byte buffer,
        // zero-length buffer, end-of-list buffer
        put_desc(32'h100, 32'h120, 32'h1001, 32'h10, 32'h1007);
        put_desc(32'h120, 32'h140, 32'h2000, 32'h00, 32'h2010);
        put_desc(32'h140, 32'h160, 32'h3002, 32'h00, 32'h3002);
        put_desc(32'h160, 32'h000, 32'h4000, 32'h01, 32'h4100);
        put_desc(32'h180, 32'h000, 32'h5003, 32'h11, 32'h5005);

        start_chan(32'h100, 32'h80);
        // R4/R5/R11: 9-byte packet spills over the 6-byte buffer, ends early
        for (int i = 0; i < 9; i++) send(8'h10 + 8'(i), i == 8);
        // R9: 5-byte packet into the end-of-list descriptor
        for (int i = 0; i < 5; i++) send(8'hA0 + 8'(i), i == 4);
        wait_stopped();

        check(exp_q.size() == 0, "R4", "writes outstanding", 32'(exp_q.size()), 32'h0);
        check(chan_stopped == 1'b1, "R9", "stopped at end of list", {31'h0, chan_stopped}, 32'h1);
        check(intr_raw == exp_raw, "R7", "intr_raw after chain", {28'h0, intr_raw}, {28'h0, exp_raw});
        check(irq == 1'b1, "R8", "irq with eop bit enabled", {31'h0, irq}, 32'h1);

        intr_mask = 4'b0100;
        #1;
        check(irq == 1'b0, "R8", "irq with unused bit enabled", {31'h0, irq}, 32'h0);
        intr_mask = 4'b0011;
        #1;
        check(irq == 1'b1, "R8", "irq with data bits enabled", {31'h0, irq}, 32'h1);

        @(negedge clk);
        intr_ack = 4'b0011;
        @(negedge clk);
        intr_ack = 4'h0;
        exp_raw &= ~4'b0011;
        check(intr_raw == exp_raw, "R8", "intr_raw after ack", {28'h0, intr_raw}, {28'h0, exp_raw});
        check(irq == 1'b0, "R8", "irq after ack", {31'h0, irq}, 32'h0);

        // R9: offered bytes refused while stopped
        begin
            int ready_seen = 0;
            s_valid = 1'b1; s_data = 8'h55; s_last = 1'b1;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (s_ready) ready_seen++;
            end
            s_valid = 1'b0; s_last = 1'b0;
            check(ready_seen == 0, "R9", "ready while stopped", 32'(ready_seen), 32'h0);
            check(intr_raw == exp_raw, "R9", "intr_raw while stopped",
                  {28'h0, intr_raw}, {28'h0, exp_raw});
        end

        // R12: restart at a new descriptor and context; fill closes, no eop
        start_chan(32'h180, 32'h90);
        send(8'hC1, 1'b0);
        send(8'hC2, 1'b0);
        wait_stopped();
        check(intr_raw == exp_raw, "R12", "intr_raw after restart", {28'h0, intr_raw}, {28'h0, exp_raw});
        check(mem[32'h5004 >> 2][7:0] == 8'hC2, "R12", "byte in new buffer",
              {24'h0, mem[32'h5004 >> 2][7:0]}, 32'hC2);
        check(exp_q.size() == 0, "R12", "writes outstanding", 32'(exp_q.size()), 32'h0);
        check(overlap == 0, "R10", "ready during memory request", 32'(overlap), 32'h0);

        finish_run();
    end

endmodule